// File: doc/BRIEF.md
# Handshake Word Crossing Between Unrelated Clocks

This block moves one data word at a time from a source clock domain into a destination clock domain whose clock has no fixed relation to the source clock. On the source side a producer offers a word with a valid/ready pair. The block latches the accepted word into a hold register and signals the other domain over a single request wire. The destination side synchronizes that request, samples the entire held word in one edge, and presents it with a strobe that lasts one cycle. An acknowledge wire then returns to the source, and the source side becomes ready again once the acknowledge has been seen.

A compile-time parameter picks the signalling style. In level mode (`PROTO = 0`) request and acknowledge rise and fall once per word, so each transfer has four edges. In toggle mode (`PROTO = 1`) each side flips its wire once per word, and the other side notices the change by comparing against a stored copy of the last synchronized value. Only request and acknowledge pass through synchronizer chains. The data bus crosses as plain wires, because the protocol keeps it unchanged for the whole time the destination may sample it.

Top module: `hs_word_xfer`

## Requirements
- R1: After either reset is released, `s_ready` is 1, `d_valid` is 0 and `d_data` is all zeros, and no word appears at the destination until a word has been accepted.
- R2: A word is accepted on a rising `clk_s` edge where `s_valid` and `s_ready` are both 1. From the cycle after acceptance, `s_ready` stays 0 until the word has been delivered and the acknowledge has been seen back in the source domain.
- R3: Every accepted word appears exactly once on `d_data`, in acceptance order and bit-exact, in the cycle where `d_valid` is 1. `d_valid` is never 1 on two consecutive `clk_d` cycles.
- R4: `d_data` keeps the last delivered word on every `clk_d` cycle where `d_valid` is 0.
- R5: With `PROTO = 0`, request returns to 0 only after the synchronized acknowledge was 1. Acknowledge rises only after the synchronized request was 1. The source is ready again only after acknowledge has been seen at 0.
- R6: With `PROTO = 1`, each accepted word causes exactly one change of request, and request changes in no other cycle.
- R7: Request passes through a chain of `SYNC_STAGES` (at least 2) flops clocked by `clk_d`, and acknowledge passes through a chain of the same depth clocked by `clk_s`. A word is never presented earlier than `SYNC_STAGES` `clk_d` edges after it was accepted.
- R8: Transfers complete correctly whether `clk_d` is slower or faster than `clk_s`.
- R9: `s_valid` and `s_data` have no effect while `s_ready` is 0. Words offered during that time are never delivered.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_s | input | 1 | Source domain clock |
| rst_s_n | input | 1 | Source domain reset, active low, asynchronous assert |
| s_valid | input | 1 | Producer offers a word |
| s_ready | output | 1 | Block can accept a word this cycle |
| s_data | input | DATA_W | Offered word |
| clk_d | input | 1 | Destination domain clock |
| rst_d_n | input | 1 | Destination domain reset, active low, asynchronous assert |
| d_valid | output | 1 | One-cycle strobe marking a newly delivered word |
| d_data | output | DATA_W | Last delivered word, held between strobes |

## Verification
The assertions assume that each reset is released cleanly in its own domain. They also assume the producer's valid/ready traffic follows the acceptance rule, so that a change of request always traces back to an accepted word. The stimulus drives inputs only on falling clock edges. It releases each reset away from that domain's rising edge. While `s_ready` is low it deliberately toggles `s_valid` and scrambles `s_data`, so the ignore rule is exercised without breaking the assumption. Both protocol variants run side by side, first with a slow destination clock and then with a fast one.

// File: rtl/hs_xfer_pkg.sv
`timescale 1ns/1ps
package hs_xfer_pkg;
  localparam int unsigned PROTO_LEVEL  = 0;
  localparam int unsigned PROTO_TOGGLE = 1;

  typedef enum logic [1:0] {
    SRC_IDLE     = 2'd0,
    SRC_WAIT_ACK = 2'd1,
    SRC_WAIT_REL = 2'd2
  } src_state_e;
endpackage

// File: rtl/hs_sync_chain.sv
`timescale 1ns/1ps
module hs_sync_chain #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] stg_q;

  // plain shift chain, nothing between stages
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_q <= '0;
    end else begin
      stg_q <= {stg_q[STAGES-2:0], d};
    end
  end

  assign q = stg_q[STAGES-1];
endmodule

// File: rtl/hs_src_side.sv
`timescale 1ns/1ps
module hs_src_side
  import hs_xfer_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned PROTO  = PROTO_LEVEL
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic              ack_sync,
  output logic              req,
  output logic [DATA_W-1:0] hold_data
);
  src_state_e        state_q, state_d;
  logic              req_q, req_d;
  logic              ackref_q, ackref_d;
  logic [DATA_W-1:0] hold_q, hold_d;
  logic              accept;

  assign in_ready = (state_q == SRC_IDLE);
  assign accept   = in_valid && in_ready;

  always_comb begin
    state_d  = state_q;
    req_d    = req_q;
    ackref_d = ackref_q;
    hold_d   = hold_q;
    case (state_q)
      SRC_IDLE: begin
        if (accept) begin
          hold_d  = in_data;
          state_d = SRC_WAIT_ACK;
          req_d   = (PROTO == PROTO_LEVEL) ? 1'b1 : ~req_q;
        end
      end
      SRC_WAIT_ACK: begin
        if (PROTO == PROTO_LEVEL) begin
          if (ack_sync) begin
            req_d   = 1'b0;
            state_d = SRC_WAIT_REL;
          end
        end else begin
          if (ack_sync != ackref_q) begin
            ackref_d = ack_sync;
            state_d  = SRC_IDLE;
          end
        end
      end
      SRC_WAIT_REL: begin
        if (!ack_sync) begin
          state_d = SRC_IDLE;
        end
      end
      default: state_d = SRC_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= SRC_IDLE;
      req_q    <= 1'b0;
      ackref_q <= 1'b0;
      hold_q   <= '0;
    end else begin
      state_q  <= state_d;
      req_q    <= req_d;
      ackref_q <= ackref_d;
      hold_q   <= hold_d;
    end
  end

  assign req       = req_q;
  assign hold_data = hold_q;

  AST_READY_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);  // R2
  AST_HOLD_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_ready && $past(!in_ready)) |-> $stable(hold_data));  // R9

  if (PROTO == PROTO_LEVEL) begin : g_level_chk
    AST_REQ_FALL_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(req_q) |-> $past(ack_sync));  // R5
    AST_READY_AFTER_ACK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(in_ready) |-> !$past(ack_sync));  // R5
  end else begin : g_toggle_chk
    AST_REQ_ONE_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
      (req_q != $past(req_q)) |-> $past(in_valid && in_ready));  // R6
  end
endmodule

// File: rtl/hs_dst_side.sv
`timescale 1ns/1ps
module hs_dst_side
  import hs_xfer_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned PROTO  = PROTO_LEVEL
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_sync,
  input  logic [DATA_W-1:0] bus_data,
  output logic              ack,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data
);
  logic              ack_q, ack_d;
  logic              reqref_q, reqref_d;
  logic              valid_q, valid_d;
  logic [DATA_W-1:0] data_q, data_d;
  logic              fire;

  if (PROTO == PROTO_LEVEL) begin : g_level
    assign fire = req_sync && !ack_q;
    always_comb begin
      reqref_d = reqref_q;
      ack_d    = ack_q;
      if (fire) begin
        ack_d = 1'b1;
      end else if (!req_sync && ack_q) begin
        ack_d = 1'b0;
      end
    end
  end else begin : g_toggle
    assign fire = (req_sync != reqref_q);
    always_comb begin
      reqref_d = reqref_q;
      ack_d    = ack_q;
      if (fire) begin
        reqref_d = req_sync;
        ack_d    = ~ack_q;
      end
    end
  end

  always_comb begin
    valid_d = fire;
    data_d  = fire ? bus_data : data_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_q    <= 1'b0;
      reqref_q <= 1'b0;
      valid_q  <= 1'b0;
      data_q   <= '0;
    end else begin
      ack_q    <= ack_d;
      reqref_q <= reqref_d;
      valid_q  <= valid_d;
      data_q   <= data_d;
    end
  end

  assign ack       = ack_q;
  assign out_valid = valid_q;
  assign out_data  = data_q;

  AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);  // R3
  AST_OUT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> $stable(out_data));  // R4

  if (PROTO == PROTO_LEVEL) begin : g_level_chk
    AST_ACK_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ack_q) |-> $past(req_sync));  // R5
  end
endmodule

// File: rtl/hs_word_xfer.sv
`timescale 1ns/1ps
module hs_word_xfer
  import hs_xfer_pkg::*;
#(
  parameter int unsigned DATA_W      = 16,
  parameter int unsigned PROTO       = PROTO_LEVEL,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_s,
  input  logic              rst_s_n,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic [DATA_W-1:0] s_data,
  input  logic              clk_d,
  input  logic              rst_d_n,
  output logic              d_valid,
  output logic [DATA_W-1:0] d_data
);
  localparam int unsigned STAGES_EFF = (SYNC_STAGES < 2) ? 2 : SYNC_STAGES;

  logic              req_w, req_at_d;
  logic              ack_w, ack_at_s;
  logic [DATA_W-1:0] held_bus;

  hs_src_side #(.DATA_W(DATA_W), .PROTO(PROTO)) u_src (
    .clk(clk_s), .rst_n(rst_s_n),
    .in_valid(s_valid), .in_ready(s_ready), .in_data(s_data),
    .ack_sync(ack_at_s), .req(req_w), .hold_data(held_bus)
  );

  hs_sync_chain #(.STAGES(STAGES_EFF)) u_req_sync (
    .clk(clk_d), .rst_n(rst_d_n), .d(req_w), .q(req_at_d)
  );

  hs_sync_chain #(.STAGES(STAGES_EFF)) u_ack_sync (
    .clk(clk_s), .rst_n(rst_s_n), .d(ack_w), .q(ack_at_s)
  );

  // held_bus crosses unsynchronized: stable while request is pending
  hs_dst_side #(.DATA_W(DATA_W), .PROTO(PROTO)) u_dst (
    .clk(clk_d), .rst_n(rst_d_n),
    .req_sync(req_at_d), .bus_data(held_bus),
    .ack(ack_w), .out_valid(d_valid), .out_data(d_data)
  );
endmodule

// File: tb/tb_hs_word_xfer.sv
`timescale 1ns/1ps
module tb_hs_word_xfer;
  localparam int W  = 16;
  localparam int SS = 2;
  localparam int N  = 40;

  logic clk_s = 1'b0;
  logic clk_d = 1'b0;
  real  half_d = 7.3;
  always #4 clk_s = ~clk_s;
  always #(half_d) clk_d = ~clk_d;

  logic         rst_s_n, rst_d_n;
  logic [1:0]   sv, sr, dv;
  logic [W-1:0] sd [2];
  logic [W-1:0] dd [2];

  hs_word_xfer #(.DATA_W(W), .PROTO(0), .SYNC_STAGES(SS)) dut (
    .clk_s(clk_s), .rst_s_n(rst_s_n), .s_valid(sv[0]), .s_ready(sr[0]),
    .s_data(sd[0]), .clk_d(clk_d), .rst_d_n(rst_d_n),
    .d_valid(dv[0]), .d_data(dd[0]));

  hs_word_xfer #(.DATA_W(W), .PROTO(1), .SYNC_STAGES(SS)) dut_tp (
    .clk_s(clk_s), .rst_s_n(rst_s_n), .s_valid(sv[1]), .s_ready(sr[1]),
    .s_data(sd[1]), .clk_d(clk_d), .rst_d_n(rst_d_n),
    .d_valid(dv[1]), .d_data(dd[1]));

  int vectors = 0;
  int fails   = 0;
  int cnt_d   = 0;
  bit running = 1'b0;
  logic [W-1:0] q0[$], q1[$];
  int t0[$], t1[$];
  int acc [2];
  int got [2];
  logic [W-1:0] last [2];
  logic pv [2];

  task automatic report(input string req, input string what, input longint act, input longint exp);
    fails++;
    $display("FAIL %s %s: actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
  endtask

  always @(posedge clk_d) cnt_d <= cnt_d + 1;

  // reference model: record accepted words in order (R2, R9)
  always @(posedge clk_s) begin
    if (rst_s_n && running) begin
      if (sv[0] && sr[0]) begin q0.push_back(sd[0]); t0.push_back(cnt_d); acc[0]++; end
      if (sv[1] && sr[1]) begin q1.push_back(sd[1]); t1.push_back(cnt_d); acc[1]++; end
    end
  end

  task automatic check_dst(input int l);
    logic [W-1:0] expw;
    int ta, sz;
    vectors++;
    if (dv[l]) begin
      if (pv[l]) report("R3", "valid held two cycles", 1, 0);
      sz = (l == 0) ? q0.size() : q1.size();
      if (sz == 0) begin
        report("R3", "strobe without accepted word", 1, 0);
      end else begin
        if (l == 0) begin expw = q0.pop_front(); ta = t0.pop_front(); end
        else        begin expw = q1.pop_front(); ta = t1.pop_front(); end
        if (dd[l] !== expw) report("R3", "delivered word", dd[l], expw);
        if (cnt_d - ta < SS) report("R7", "latency in dst edges", cnt_d - ta, SS);
        got[l]++;
      end
      last[l] = dd[l];
    end else if (dd[l] !== last[l]) begin
      report("R4", "output not held", dd[l], last[l]);
    end
    pv[l] = dv[l];
  endtask

  always @(negedge clk_d) begin
    if (running) begin
      check_dst(0);
      check_dst(1);
    end
  end

  // R2: ready must stay low while a word is in flight
  always @(negedge clk_s) begin
    if (running) begin
      for (int l = 0; l < 2; l++) begin
        vectors++;
        if ((acc[l] - got[l]) > 0 && sr[l]) report("R2", "ready while word in flight", 1, 0);
      end
    end
  end

  task automatic run_phase(input real hd, input string tag);
    half_d  = hd;
    running = 1'b0;
    sv      = 2'b00;
    rst_s_n = 1'b0;
    rst_d_n = 1'b0;
    repeat (5) @(negedge clk_s);
    q0.delete(); q1.delete(); t0.delete(); t1.delete();
    for (int l = 0; l < 2; l++) begin
      acc[l] = 0; got[l] = 0; last[l] = '0; pv[l] = 1'b0; sd[l] = '0;
    end
    @(negedge clk_s); rst_s_n = 1'b1;
    @(negedge clk_d); rst_d_n = 1'b1;
    @(negedge clk_s);
    // R1: reset state on both variants
    vectors++; if (sr !== 2'b11) report("R1", {"ready after reset ", tag}, sr, 2'b11);
    vectors++; if (dv !== 2'b00) report("R1", {"valid after reset ", tag}, dv, 2'b00);
    for (int l = 0; l < 2; l++) begin
      vectors++; if (dd[l] !== '0) report("R1", {"data after reset ", tag}, dd[l], 0);
    end
    running = 1'b1;
    // R8 via phase clock ratio; R9 via junk offered while busy
    while (acc[0] < N || acc[1] < N) begin
      @(negedge clk_s);
      for (int l = 0; l < 2; l++) begin
        if (acc[l] >= N) begin
          sv[l] = 1'b0;
        end else if (sr[l]) begin
          sv[l] = (($urandom % 4) != 0);
          sd[l] = W'($urandom);
        end else begin
          sv[l] = 1'($urandom % 2);
          sd[l] = W'($urandom);
        end
      end
    end
    @(negedge clk_s);
    sv = 2'b00;
    for (int k = 0; k < 3000; k++) begin
      @(negedge clk_s);
      if (got[0] == N && got[1] == N && sr == 2'b11) break;
    end
    for (int l = 0; l < 2; l++) begin
      vectors++;
      if (got[l] != N) report(l == 0 ? "R5" : "R6", {"words delivered ", tag}, got[l], N);
      vectors++;
      if (sr[l] !== 1'b1) report("R2", {"ready after drain ", tag}, sr[l], 1);
    end
    running = 1'b0;
  endtask

  task automatic finish_run();
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  initial begin
    rst_s_n = 1'b0;
    rst_d_n = 1'b0;
    sv = 2'b00;
    sd[0] = '0; sd[1] = '0;
    run_phase(7.3, "slow dst");
    run_phase(1.7, "fast dst");
    finish_run();
  end

  initial begin
    #1000000;
    fails++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end
endmodule